// File: doc/BRIEF.md
# Trap Arbitration and Type Encoder

This block gathers every pending trap source of an integer pipeline in a single cycle and decides what happens next. The sources are a reset request, two memory-exception flags, nine synchronous condition flags, and a 4-bit interrupt request level. The 4-bit interrupt level is compared with the processor interrupt priority level. Exactly one winner is chosen by fixed priority. The block then reports, one cycle later, whether a trap is taken, whether the processor must instead stop in error mode, whether the winner was reset, and the 8-bit trap type code.

Trap enable (`trap_en`) splits the sources into two classes. Interrupts and memory exceptions are asynchronous and are simply dropped while traps are disabled. Every other flag is synchronous, and with traps disabled it produces an error-mode indication carrying the cause code in place of a trap. Trap type codes below 0x80 belong to hardware causes. Codes 0x80 and above belong to software trap instructions. Losing requests are not remembered: a source must still be asserted in a later cycle to be taken. There is no data stream here, so all pins are plain level control and status signals with no handshake.

Top module: `trap_arbiter`

## Requirements
- R1: While `rst_n` is low, `trap_take`, `error_mode` and `is_reset` are 0 and `tt` is 0x00.
- R2: A sampled `reset_req` wins over every other source and ignores `trap_en`. In the next cycle, `trap_take`=1, `is_reset`=1, `error_mode`=0 and `tt`=0x00.
- R3: Without reset, the winner follows this fixed order, from highest to lowest, with these codes: instruction-fetch memory exception 0x01, illegal instruction 0x02, privilege violation 0x03, floating point off 0x04, coprocessor off 0x24, window overflow 0x05, window underflow 0x06, misaligned address 0x07, data memory exception 0x09, tag overflow 0x0A, software trap, and lastly interrupts.
- R4: An interrupt level `irq_lvl` is a request only when it is nonzero and strictly greater than `pil`. It is then taken with code 0x10 + `irq_lvl`.
- R5: Level 15 is non-maskable. It is taken with code 0x1F even when `pil` is 15.
- R6: While `trap_en`=0, interrupts and both memory exceptions cause neither `trap_take` nor `error_mode`, and `tt` is unchanged.
- R7: While `trap_en`=0, any synchronous source gives `error_mode`=1 and `trap_take`=0 in the next cycle. `tt` then holds the code of the highest synchronous source. `trap_take` and `error_mode` are never high together.
- R8: A software trap uses code 0x80 | `sw_num[6:0]`. Every hardware code is below 0x80.
- R9: `trap_take` and `error_mode` reflect only the inputs sampled at the previous edge, so each is high for one cycle per sampled request. `tt` keeps its last value while neither is high.
- R10: Lower-priority requests pending together with a winner are discarded. They produce no later trap unless they are still asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| reset_req | input | 1 | Reset trap request |
| trap_en | input | 1 | Traps enabled |
| pil | input | 4 | Processor interrupt priority level |
| irq_lvl | input | 4 | Interrupt request level, 0 = none |
| ifetch_mexc | input | 1 | Memory exception on instruction fetch |
| illegal_op | input | 1 | Illegal instruction |
| priv_viol | input | 1 | Privileged instruction in user mode |
| fp_off | input | 1 | Floating-point operation while disabled |
| cp_off | input | 1 | Coprocessor operation while disabled |
| win_ovf | input | 1 | Register window overflow |
| win_unf | input | 1 | Register window underflow |
| misalign | input | 1 | Misaligned address |
| data_mexc | input | 1 | Memory exception on data access |
| tag_ovf | input | 1 | Tagged arithmetic overflow |
| sw_hit | input | 1 | Software trap instruction condition met |
| sw_num | input | 7 | Software trap number |
| trap_take | output | 1 | Trap taken (one cycle) |
| error_mode | output | 1 | Synchronous trap with traps disabled (one cycle) |
| is_reset | output | 1 | Taken trap is a reset |
| tt | output | 8 | Trap type code |

## Verification
The hardest situation to reach is the one where trap disable reshapes the priority. A higher-ranked asynchronous source, such as an instruction-fetch memory exception, must vanish while a lower synchronous flag is reported as an error cause. A non-maskable interrupt must also be dropped when it would otherwise win. The stimulus table drives `trap_en`=0 together with mixed asynchronous and synchronous flags and with level 15. It also covers the boundary `irq_lvl`==`pil` and the case `pil`=15 with level 15. A directed sequence then asserts reset together with other sources while traps are off.

// File: rtl/trap_arb_pkg.sv
package trap_arb_pkg;
  localparam int NSRC  = 12;
  localparam int IDX_W = $clog2(NSRC);
  localparam int TT_W  = 8;

  // index 0 = highest priority
  typedef enum logic [IDX_W-1:0] {
    S_IFETCH_MEM = 4'd0, S_ILLEGAL = 4'd1, S_PRIV = 4'd2, S_FP_OFF = 4'd3,
    S_CP_OFF = 4'd4, S_WIN_OVF = 4'd5, S_WIN_UNF = 4'd6, S_MISALIGN = 4'd7,
    S_DATA_MEM = 4'd8, S_TAG_OVF = 4'd9, S_SWTRAP = 4'd10, S_IRQ = 4'd11
  } src_e;

  // sources dropped while traps are disabled
  localparam logic [NSRC-1:0] ASYNC_SET =
    (NSRC'(1) << S_IFETCH_MEM) | (NSRC'(1) << S_DATA_MEM) | (NSRC'(1) << S_IRQ);

  localparam logic [TT_W-1:0] TT_RESET    = 8'h00;
  localparam logic [TT_W-1:0] TT_IRQ_BASE = 8'h10;
  localparam logic [TT_W-1:0] TT_SW_BASE  = 8'h80;
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int LVL_W = 4
) (
  input  logic [LVL_W-1:0] irq_lvl,
  input  logic [LVL_W-1:0] pil,
  output logic             accept
);
  always_comb begin
    accept = 1'b0;
    if (irq_lvl != '0)
      accept = (irq_lvl == '1) || (irq_lvl > pil);
  end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N = 12,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) idx = IW'(i);
    any = |req;
  end
endmodule

// File: rtl/trap_code_enc.sv
module trap_code_enc
  import trap_arb_pkg::*;
#(
  parameter int LVL_W = 4,
  parameter int SWN_W = 7
) (
  input  logic [IDX_W-1:0] src_idx,
  input  logic [LVL_W-1:0] irq_lvl,
  input  logic [SWN_W-1:0] sw_num,
  output logic [TT_W-1:0]  code
);
  always_comb begin
    unique case (src_e'(src_idx))
      S_IFETCH_MEM: code = 8'h01;
      S_ILLEGAL:    code = 8'h02;
      S_PRIV:       code = 8'h03;
      S_FP_OFF:     code = 8'h04;
      S_CP_OFF:     code = 8'h24;
      S_WIN_OVF:    code = 8'h05;
      S_WIN_UNF:    code = 8'h06;
      S_MISALIGN:   code = 8'h07;
      S_DATA_MEM:   code = 8'h09;
      S_TAG_OVF:    code = 8'h0A;
      S_SWTRAP:     code = TT_SW_BASE | TT_W'(sw_num);
      S_IRQ:        code = TT_IRQ_BASE + TT_W'(irq_lvl);
      default:      code = TT_RESET;
    endcase
  end
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_arb_pkg::*;
#(
  parameter int LVL_W = 4,
  parameter int SWN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reset_req,
  input  logic             trap_en,
  input  logic [LVL_W-1:0] pil,
  input  logic [LVL_W-1:0] irq_lvl,
  input  logic             ifetch_mexc,
  input  logic             illegal_op,
  input  logic             priv_viol,
  input  logic             fp_off,
  input  logic             cp_off,
  input  logic             win_ovf,
  input  logic             win_unf,
  input  logic             misalign,
  input  logic             data_mexc,
  input  logic             tag_ovf,
  input  logic             sw_hit,
  input  logic [SWN_W-1:0] sw_num,
  output logic             trap_take,
  output logic             error_mode,
  output logic             is_reset,
  output logic [TT_W-1:0]  tt
);
  logic             irq_ok;
  logic [NSRC-1:0]  raw_req;
  logic [NSRC-1:0]  elig_req;
  logic             elig_any;
  logic [IDX_W-1:0] win_idx;
  logic [TT_W-1:0]  win_code;

  irq_qualify #(.LVL_W(LVL_W)) u_irq (
    .irq_lvl(irq_lvl), .pil(pil), .accept(irq_ok)
  );

  always_comb begin
    raw_req               = '0;
    raw_req[S_IFETCH_MEM] = ifetch_mexc;
    raw_req[S_ILLEGAL]    = illegal_op;
    raw_req[S_PRIV]       = priv_viol;
    raw_req[S_FP_OFF]     = fp_off;
    raw_req[S_CP_OFF]     = cp_off;
    raw_req[S_WIN_OVF]    = win_ovf;
    raw_req[S_WIN_UNF]    = win_unf;
    raw_req[S_MISALIGN]   = misalign;
    raw_req[S_DATA_MEM]   = data_mexc;
    raw_req[S_TAG_OVF]    = tag_ovf;
    raw_req[S_SWTRAP]     = sw_hit;
    raw_req[S_IRQ]        = irq_ok;
    elig_req = trap_en ? raw_req : (raw_req & ~ASYNC_SET);
  end

  prio_pick #(.N(NSRC)) u_pick (
    .req(elig_req), .any(elig_any), .idx(win_idx)
  );

  trap_code_enc #(.LVL_W(LVL_W), .SWN_W(SWN_W)) u_enc (
    .src_idx(win_idx), .irq_lvl(irq_lvl), .sw_num(sw_num), .code(win_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_take  <= 1'b0;
      error_mode <= 1'b0;
      is_reset   <= 1'b0;
      tt         <= TT_RESET;
    end else begin
      trap_take  <= 1'b0;
      error_mode <= 1'b0;
      is_reset   <= 1'b0;
      if (reset_req) begin
        trap_take <= 1'b1;
        is_reset  <= 1'b1;
        tt        <= TT_RESET;
      end else if (elig_any) begin
        trap_take  <= trap_en;
        error_mode <= !trap_en;
        tt         <= win_code;
      end
    end
  end
endmodule

// File: rtl/trap_arbiter_chk.sv
module trap_arbiter_chk #(
  parameter int LVL_W = 4,
  parameter int SWN_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reset_req,
  input logic             trap_en,
  input logic [LVL_W-1:0] pil,
  input logic [LVL_W-1:0] irq_lvl,
  input logic             ifetch_mexc,
  input logic             illegal_op,
  input logic             priv_viol,
  input logic             fp_off,
  input logic             cp_off,
  input logic             win_ovf,
  input logic             win_unf,
  input logic             misalign,
  input logic             data_mexc,
  input logic             tag_ovf,
  input logic             sw_hit,
  input logic [SWN_W-1:0] sw_num,
  input logic             trap_take,
  input logic             error_mode,
  input logic             is_reset,
  input logic [7:0]       tt
);
  logic any_flag;
  assign any_flag = ifetch_mexc | illegal_op | priv_viol | fp_off | cp_off |
                    win_ovf | win_unf | misalign | data_mexc | tag_ovf | sw_hit;

  assert_reset_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> (trap_take && is_reset && !error_mode && tt == 8'h00));

  assert_reset_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_reset |-> trap_take);

  assert_nmi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_en && !reset_req && !any_flag && irq_lvl == '1) |=> (trap_take && tt == 8'h1F));

  assert_async_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_en && !reset_req) |=> !trap_take);

  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_take && error_mode));

  assert_sw_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && tt[7]) |-> $past(sw_hit));

  assert_tt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_take && !error_mode) |-> $stable(tt));
endmodule

bind trap_arbiter trap_arbiter_chk #(.LVL_W(LVL_W), .SWN_W(SWN_W)) u_chk (.*);

// File: tb/test_trap_arbiter.sv
`timescale 1ns/1ps
module test_trap_arbiter;
  logic clk = 1'b0;
  logic rst_n, reset_req, trap_en;
  logic [3:0] pil, irq_lvl;
  logic ifetch_mexc, illegal_op, priv_viol, fp_off, cp_off, win_ovf, win_unf;
  logic misalign, data_mexc, tag_ovf, sw_hit;
  logic [6:0] sw_num;
  logic trap_take, error_mode, is_reset;
  logic [7:0] tt;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_tt = 8'h00;

  always #5 clk = ~clk;

  trap_arbiter i_trap_arbiter (.*);

  // src bit order: 0 ifetch_mexc,1 illegal,2 priv,3 fp_off,4 cp_off,5 win_ovf,
  // 6 win_unf,7 misalign,8 data_mexc,9 tag_ovf,10 sw_hit
  typedef struct packed {
    logic       et;
    logic [3:0] pil;
    logic [3:0] irl;
    logic [10:0] src;
    logic [6:0] num;
    logic       take;
    logic       err;
    logic [7:0] tt;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'd0,  4'd0,  11'h000, 7'h00, 1'b0, 1'b0, 8'h00}, // idle
    '{1'b1, 4'd0,  4'd0,  11'h002, 7'h00, 1'b1, 1'b0, 8'h02}, // R3
    '{1'b1, 4'd0,  4'd0,  11'h206, 7'h00, 1'b1, 1'b0, 8'h02}, // R10
    '{1'b1, 4'd0,  4'd0,  11'h024, 7'h00, 1'b1, 1'b0, 8'h03}, // R3
    '{1'b1, 4'd0,  4'd0,  11'h008, 7'h00, 1'b1, 1'b0, 8'h04}, // R3
    '{1'b1, 4'd0,  4'd0,  11'h010, 7'h00, 1'b1, 1'b0, 8'h24}, // R3
    '{1'b1, 4'd0,  4'd0,  11'h060, 7'h00, 1'b1, 1'b0, 8'h05}, // R3
    '{1'b1, 4'd0,  4'd0,  11'h040, 7'h00, 1'b1, 1'b0, 8'h06}, // R3
    '{1'b1, 4'd0,  4'd0,  11'h180, 7'h00, 1'b1, 1'b0, 8'h07}, // R3
    '{1'b1, 4'd0,  4'd0,  11'h300, 7'h00, 1'b1, 1'b0, 8'h09}, // R3
    '{1'b1, 4'd0,  4'd0,  11'h600, 7'h05, 1'b1, 1'b0, 8'h0A}, // R3
    '{1'b1, 4'd0,  4'd0,  11'h400, 7'h7F, 1'b1, 1'b0, 8'hFF}, // R8
    '{1'b1, 4'd0,  4'd3,  11'h400, 7'h00, 1'b1, 1'b0, 8'h80}, // R8 sw over irq
    '{1'b1, 4'd4,  4'd5,  11'h000, 7'h00, 1'b1, 1'b0, 8'h15}, // R4
    '{1'b1, 4'd4,  4'd4,  11'h000, 7'h00, 1'b0, 1'b0, 8'h00}, // R4 equal -> none
    '{1'b1, 4'd7,  4'd3,  11'h000, 7'h00, 1'b0, 1'b0, 8'h00}, // R4 below
    '{1'b1, 4'd15, 4'd15, 11'h000, 7'h00, 1'b1, 1'b0, 8'h1F}, // R5
    '{1'b1, 4'd0,  4'd0,  11'h000, 7'h00, 1'b0, 1'b0, 8'h00}, // R4 level 0
    '{1'b1, 4'd0,  4'd0,  11'h003, 7'h00, 1'b1, 1'b0, 8'h01}, // R3
    '{1'b0, 4'd0,  4'd0,  11'h001, 7'h00, 1'b0, 1'b0, 8'h00}, // R6
    '{1'b0, 4'd0,  4'd15, 11'h100, 7'h00, 1'b0, 1'b0, 8'h00}, // R6
    '{1'b0, 4'd0,  4'd0,  11'h180, 7'h00, 1'b0, 1'b1, 8'h07}, // R7
    '{1'b0, 4'd0,  4'd0,  11'h009, 7'h00, 1'b0, 1'b1, 8'h04}, // R7
    '{1'b0, 4'd0,  4'd0,  11'h400, 7'h03, 1'b0, 1'b1, 8'h83}, // R7
    '{1'b1, 4'd2,  4'd9,  11'h400, 7'h03, 1'b1, 1'b0, 8'h83}  // R3 sw over irq
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic et, input logic [3:0] p, input logic [3:0] l,
                       input logic [10:0] s, input logic [6:0] n);
    trap_en = et; pil = p; irq_lvl = l; sw_num = n;
    {sw_hit, tag_ovf, data_mexc, misalign, win_unf, win_ovf,
     cp_off, fp_off, priv_viol, illegal_op, ifetch_mexc} = s;
  endtask

  task automatic chk_all(input string req, input logic t, input logic e,
                         input logic r, input logic [7:0] code);
    chk({req, " trap_take"},  {7'd0, trap_take},  {7'd0, t});
    chk({req, " error_mode"}, {7'd0, error_mode}, {7'd0, e});
    chk({req, " is_reset"},   {7'd0, is_reset},   {7'd0, r});
    chk({req, " tt"},         tt,                 code);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reset_req = 1'b0;
    drive(1'b1, 4'd0, 4'd0, 11'h7FF, 7'h7F);
    repeat (3) @(negedge clk);
    chk_all("R1", 1'b0, 1'b0, 1'b0, 8'h00);
    drive(1'b1, 4'd0, 4'd0, 11'h000, 7'h00);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      drive(VECS[k].et, VECS[k].pil, VECS[k].irl, VECS[k].src, VECS[k].num);
      @(negedge clk);
      if (VECS[k].take || VECS[k].err) exp_tt = VECS[k].tt;
      chk_all($sformatf("R3/R4/R6/R7/R8 vector %0d", k),
              VECS[k].take, VECS[k].err, 1'b0, exp_tt);
    end

    // R2: reset wins with traps disabled and other sources present
    drive(1'b0, 4'd0, 4'd15, 11'h003, 7'h00);
    reset_req = 1'b1;
    @(negedge clk);
    chk_all("R2", 1'b1, 1'b0, 1'b1, 8'h00);
    reset_req = 1'b0;
    @(negedge clk);
    chk_all("R7 after reset", 1'b0, 1'b1, 1'b0, 8'h02);
    drive(1'b1, 4'd0, 4'd0, 11'h000, 7'h00);
    @(negedge clk);
    chk_all("R9 hold", 1'b0, 1'b0, 1'b0, 8'h02);

    // R9/R10: one-cycle pulse, discarded lower source not remembered
    drive(1'b1, 4'd0, 4'd0, 11'h084, 7'h00);
    @(negedge clk);
    chk_all("R10 win", 1'b1, 1'b0, 1'b0, 8'h03);
    drive(1'b1, 4'd0, 4'd0, 11'h000, 7'h00);
    @(negedge clk);
    chk_all("R10 discarded", 1'b0, 1'b0, 1'b0, 8'h03);
    @(negedge clk);
    chk_all("R9 idle", 1'b0, 1'b0, 1'b0, 8'h03);

    // R1: mid-run reset clears outputs
    drive(1'b1, 4'd0, 4'd0, 11'h002, 7'h00);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_all("R1 midrun", 1'b0, 1'b0, 1'b0, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule